// File: doc/BRIEF.md
# Audio Output Soft-Mute Controller

This block sits after a sample-rate converter and gates the audio samples that leave it. Each converted sample arrives as a signed word with a one-cycle strobe. A single validity input carries the AND of every upstream fault source. A mode input says whether the converter is interpolating (input rate below output rate) or decimating (input rate above output rate). The block registers each sample after multiplying it by a gain. While data is invalid, or straight after reset, that gain is zero.

Muting is asymmetric. If validity falls, the output drops to zero on the next clock with no fade. Once validity returns, a counter raises the gain linearly from zero to exactly one. The length of that ramp depends on the mode. In interpolation mode it lasts 27488 input-rate ticks. In decimation mode it lasts 54976 output-rate ticks. Both tick sources come in as separate strobes, and only the one that matches the mode advances the ramp. If the mode changes, or validity drops partway through a ramp, the ramp starts again from zero.

Top module: `soft_mute_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it is released, `out_data` is 0, `out_stb` is 0 and `mute_hard` is 1.
- R2: On the clock after `src_valid` is sampled low, `out_data` is 0, `mute_hard` is 1 and the ramp count is cleared.
- R3: With `decim_mode` = 0 and `src_valid` high, the ramp count rises by one on each clock where `fsi_tick` is 1. `mute_done` goes high after exactly 27488 such ticks. `fso_tick` has no effect in this mode.
- R4: With `decim_mode` = 1 and `src_valid` high, the ramp count rises by one on each clock where `fso_tick` is 1. `mute_done` goes high after exactly 54976 such ticks. `fsi_tick` has no effect in this mode.
- R5: Let the ramp count be c and the ramp length be L. Below the terminal count the gain is c·floor(2^24/L) in 24-bit fraction format. The registered output is (x·gain + 2^23) shifted right arithmetically by 24, truncated to the sample width.
- R6: At the terminal count the gain is exactly 2^24, so `out_data` equals the input sample bit for bit.
- R7: If validity drops during a ramp, a later recovery restarts the full ramp from count 0.
- R8: A change of `decim_mode` while valid clears the ramp count on the next clock (`mute_hard` = 1). The new ramp then uses the new mode's length and tick.
- R9: Exactly one status flag is high at all times. `mute_hard` means count 0. `mute_ramp` means 0 < count < L. `mute_done` means count = L.
- R10: `out_stb` is `in_stb` delayed by one clock. `out_data` loads only on a strobe while valid, and otherwise holds (or is zero when invalid).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DATA_W | Signed sample from the converter |
| in_stb | input | 1 | Sample strobe for `in_data` |
| src_valid | input | 1 | High when every upstream invalid condition is clear |
| decim_mode | input | 1 | 0 = interpolation, 1 = decimation |
| fsi_tick | input | 1 | One pulse per input-rate sample period |
| fso_tick | input | 1 | One pulse per output-rate sample period |
| out_data | output | DATA_W | Scaled or muted sample |
| out_stb | output | 1 | Strobe for `out_data` |
| mute_hard | output | 1 | Output forced to zero (gain 0) |
| mute_ramp | output | 1 | Gain rising |
| mute_done | output | 1 | Unity gain reached |

## Verification
A wrong ramp count shows at the ports on the next strobed sample. The scaled value differs from the linear gain law, or `mute_done` rises on the wrong tick, which the bench catches by counting ticks to the flag. A count that is not cleared on loss of validity or on a mode change shows one clock later, as a nonzero sample or a missing `mute_hard`. A wrong tick selection shows as a ramp that ends too early or too late. Off-by-one rounding shows on the first random sample taken at that gain.

// File: rtl/soft_mute_ctrl.sv
module soft_mute_ctrl #(
  parameter int DATA_W     = 24,
  parameter int GAIN_FRAC  = 24,
  parameter int INTERP_LEN = 27488,
  parameter int DECIM_LEN  = 54976
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_stb,
  input  logic              src_valid,
  input  logic              decim_mode,
  input  logic              fsi_tick,
  input  logic              fso_tick,
  output logic [DATA_W-1:0] out_data,
  output logic              out_stb,
  output logic              mute_hard,
  output logic              mute_ramp,
  output logic              mute_done
);

  localparam int MAX_LEN = (INTERP_LEN > DECIM_LEN) ? INTERP_LEN : DECIM_LEN;
  localparam int CW      = $clog2(MAX_LEN + 1);
  localparam int GW      = GAIN_FRAC + 1;
  localparam int PW      = DATA_W + GAIN_FRAC + 2;
  localparam logic [GW-1:0] UNITY   = GW'(1) << GAIN_FRAC;
  localparam logic [GW-1:0] RECIP_I = GW'((64'd1 << GAIN_FRAC) / INTERP_LEN);
  localparam logic [GW-1:0] RECIP_D = GW'((64'd1 << GAIN_FRAC) / DECIM_LEN);
  localparam logic [PW-1:0] HALF    = PW'(1) << (GAIN_FRAC - 1);

  logic [CW-1:0] cnt;
  logic          mode_q;

  logic [CW-1:0] len_now, len_q;
  logic          tick_sel, mode_chg, at_end;
  logic [GW-1:0] gain;
  logic signed [PW-1:0] prod, rounded, scaled;

  assign len_now  = decim_mode ? CW'(DECIM_LEN) : CW'(INTERP_LEN);
  assign len_q    = mode_q ? CW'(DECIM_LEN) : CW'(INTERP_LEN);
  assign tick_sel = decim_mode ? fso_tick : fsi_tick;
  assign mode_chg = decim_mode != mode_q;
  assign at_end   = cnt == len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= decim_mode;
      if (!src_valid || mode_chg)
        cnt <= '0;
      else if (tick_sel && cnt != len_now)
        cnt <= cnt + 1'b1;
    end
  end

  assign gain    = at_end ? UNITY
                 : GW'(cnt) * (mode_q ? RECIP_D : RECIP_I);
  assign prod    = PW'($signed(in_data)) * $signed({1'b0, gain});
  assign rounded = prod + $signed(HALF);
  assign scaled  = rounded >>> GAIN_FRAC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data <= '0;
      out_stb  <= 1'b0;
    end else begin
      out_stb <= in_stb;
      if (!src_valid)
        out_data <= '0;
      else if (in_stb)
        out_data <= scaled[DATA_W-1:0];
    end
  end

  assign mute_hard = cnt == '0;
  assign mute_done = at_end && !mute_hard;
  assign mute_ramp = !mute_hard && !at_end;

  assert_status_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({mute_hard, mute_ramp, mute_done}));

  assert_hard_mute_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !src_valid |=> (out_data == '0) && mute_hard);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= len_q);

  assert_tick_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && !mode_chg && !tick_sel) |=> $stable(cnt));

  assert_mode_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && mode_chg) |=> mute_hard);

  assert_unity_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_done && src_valid && in_stb) |=> out_data == $past(in_data));

  assert_strobe_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb |=> out_stb);

endmodule

// File: tb/soft_mute_ctrl_tb.sv
module soft_mute_ctrl_tb;
  localparam int W  = 24;
  localparam int LI = 27488;
  localparam int LD = 54976;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_stb = 1'b0, src_valid = 1'b0, decim_mode = 1'b0;
  logic fsi_tick = 1'b0, fso_tick = 1'b0;
  logic [W-1:0] out_data;
  logic out_stb, mute_hard, mute_ramp, mute_done;

  int tests = 0, fails = 0;
  int fsi_pol = 0, fso_pol = 0;   // 0 random, 1 always high
  int m_cnt = 0;
  logic m_mode = 1'b0;
  logic [W-1:0] m_out = '0;
  logic m_stb = 1'b0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  soft_mute_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_stb(in_stb),
    .src_valid(src_valid), .decim_mode(decim_mode),
    .fsi_tick(fsi_tick), .fso_tick(fso_tick),
    .out_data(out_data), .out_stb(out_stb),
    .mute_hard(mute_hard), .mute_ramp(mute_ramp), .mute_done(mute_done));

  function automatic int ramp_len(logic m);
    return m ? LD : LI;
  endfunction

  function automatic logic [W-1:0] exp_scale(logic [W-1:0] x, int c, logic m);
    longint g, p, xs;
    int l = ramp_len(m);
    xs = longint'($signed(x));
    g  = (c == l) ? (64'sd1 <<< 24) : longint'(c) * ((64'sd1 <<< 24) / l);
    p  = (xs * g + (64'sd1 <<< 23)) >>> 24;
    return p[W-1:0];
  endfunction

  task automatic check(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_mode <= 1'b0; m_out <= '0; m_stb <= 1'b0;
    end else begin
      m_mode <= decim_mode;
      m_stb  <= in_stb;
      if (!src_valid || decim_mode != m_mode) m_cnt <= 0;
      else if ((decim_mode ? fso_tick : fsi_tick) && m_cnt != ramp_len(decim_mode))
        m_cnt <= m_cnt + 1;
      if (!src_valid) m_out <= '0;
      else if (in_stb) m_out <= exp_scale(in_data, m_cnt, m_mode);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      check("R5/R6 out_data", longint'(out_data), longint'(m_out));
      check("R10 out_stb", longint'(out_stb), longint'(m_stb));
      check("R9 mute_hard", longint'(mute_hard), longint'(m_cnt == 0));
      check("R9 mute_done", longint'(mute_done), longint'(m_cnt == ramp_len(m_mode) && m_cnt != 0));
      check("R9 mute_ramp", longint'(mute_ramp),
            longint'(m_cnt != 0 && m_cnt != ramp_len(m_mode)));
    end
    in_stb <= ($urandom % 3) == 0;
    case ($urandom % 5)
      0: in_data <= 24'h7FFFFF;
      1: in_data <= 24'h800000;
      default: in_data <= W'($urandom);
    endcase
    fsi_tick <= (fsi_pol == 1) ? 1'b1 : 1'(($urandom % 2));
    fso_tick <= (fso_pol == 1) ? 1'b1 : 1'(($urandom % 2));
  end

  task automatic count_to_done(string req, int exp);
    int n = 0;
    while (!mute_done && n < 70000) begin
      @(negedge clk);
      n++;
    end
    check(req, n, exp);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check("R1 reset out_data", longint'(out_data), 0);
    check("R1 reset mute_hard", longint'(mute_hard), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release out_stb", longint'(out_stb), longint'(m_stb));
    check("R1 after release mute_hard", longint'(mute_hard), 1);
    check("R1 after release out_data", longint'(out_data), 0);

    // R3: interpolation ramp, fso random and ignored
    fsi_pol = 1; fso_pol = 0;
    @(negedge clk);
    src_valid = 1'b1;
    count_to_done("R3 interp ramp length", LI);
    repeat (50) @(negedge clk);

    // R2/R7: drop mid-ramp, then full restart
    src_valid = 1'b0;
    @(negedge clk);
    check("R2 hard mute data", longint'(out_data), 0);
    check("R2 hard mute flag", longint'(mute_hard), 1);
    src_valid = 1'b1;
    repeat (500) @(negedge clk);
    src_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 drop mid-ramp flag", longint'(mute_hard), 1);
    src_valid = 1'b1;
    count_to_done("R7 restarted ramp length", LI);

    // R8: mode change mid-ramp, then decimation ramp R4 with fsi random
    src_valid = 1'b0;
    @(negedge clk);
    src_valid = 1'b1;
    repeat (1000) @(negedge clk);
    check("R8 ramping before switch", longint'(mute_ramp), 1);
    fsi_pol = 0; fso_pol = 1;
    decim_mode = 1'b1;
    @(negedge clk);
    check("R8 restart on mode change", longint'(mute_hard), 1);
    count_to_done("R4 decim ramp length", LD);
    repeat (200) @(negedge clk);

    // random valid toggling in both modes
    fso_pol = 0;
    for (int i = 0; i < 2000; i++) begin
      src_valid = ($urandom % 20) != 0;
      if (($urandom % 300) == 0) decim_mode = ~decim_mode;
      @(negedge clk);
    end

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule